// File: doc/BRIEF.md
# Lookup Table Indirect Access Window

This block holds an address lookup table of 68-bit entries. Software reaches the table through a small register window rather than a direct mapping. Three 32-bit staging words hold one entry. A single table-control register carries an entry index and a direction bit. Writing the control register either loads the chosen entry into the staging words or commits the staging words into the chosen entry. Loads and commits take effect on the clock edge that accepts the write, so software never polls.

A command register clears the whole table in a single cycle by marking every entry free. Two decoded views of the staging words are driven as outputs: the entry type and the 48-bit MAC address. Neighbouring logic can use these without unpacking the words.

A read-modify-write needs only one load. The staging words keep their contents after a commit, so software loads once, edits the words it needs, and commits.

Top module: `lut_window`

## Requirements
- R1: After reset every staging word reads zero, both decoded outputs are zero, and every table entry is zero (type free).
- R2: Register offsets are 0, 1, 2 for the staging words and 3 for table control. Word 0 holds entry bits 67:64 in its bits 3:0, and its bits 31:4 read zero. Word 1 holds bits 63:32 and word 2 holds bits 31:0. A field starting at entry bit p therefore lives in word 2−floor(p/32) at offset p mod 32.
- R3: A write to table control with bit 31 clear and an index in bits 15:0 below DEPTH copies that entry into the staging words. The new contents are readable from the next cycle.
- R4: A write to table control with bit 31 set and an in-range index stores the staging words into that entry.
- R5: A commit leaves the staging words unchanged.
- R6: A load with an index at or above DEPTH sets all staging words to zero.
- R7: A commit with an index at or above DEPTH changes no table entry.
- R8: Writing the command register (offset 4) with bit 0 set makes the type field (bits 61:60) of every entry zero. All other entry bits and the staging words are unchanged.
- R9: Output `ent_type` equals staging bits 61:60, with the encodings 0 free, 1 address, 2 VLAN, 3 VLAN plus address. Output `ent_mac` equals staging bits 47:0, with address byte 0 at bits 47:40 and byte 5 at bits 7:0.
- R10: Reads of offsets 3 through 7 return zero. Writes to offsets 5 through 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ent_type | output | 2 | Type field of the staging entry |
| ent_mac | output | 48 | MAC address field of the staging entry |

## Verification
The assertions take for granted that at most one register write arrives per cycle. Because of this, a load, a commit and a clear never share an edge. They also take for granted that the index field is the only part of a control write that selects an entry. The stimulus issues writes one at a time and walks indices on both sides of the depth limit, including an out-of-range index whose low bits alias a valid entry. It interleaves clears with loads and commits, so the aliasing and the partial-field nature of a clear are both exercised.

// File: rtl/lut_window.sv
module lut_window #(
  parameter int DEPTH  = 64,
  parameter int IDXF_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [1:0]  ent_type,
  output logic [47:0] ent_mac
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ENT_W = 68;

  logic [ENT_W-1:0] tbl [DEPTH];
  logic [ENT_W-1:0] stage_q;

  logic [IDXF_W-1:0] ctl_idx;
  logic [IDX_W-1:0]  tbl_idx;
  logic              idx_ok;
  logic              ctl_wr, do_load, do_commit, do_clear;

  assign ctl_idx   = reg_wdata[IDXF_W-1:0];
  assign tbl_idx   = ctl_idx[IDX_W-1:0];
  assign idx_ok    = 32'(ctl_idx) < DEPTH;
  assign ctl_wr    = reg_wr && reg_addr == 3'd3;
  assign do_load   = ctl_wr && !reg_wdata[31];
  assign do_commit = ctl_wr &&  reg_wdata[31] && idx_ok;
  assign do_clear  = reg_wr && reg_addr == 3'd4 && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0: stage_q[67:64] <= reg_wdata[3:0];
        3'd1: stage_q[63:32] <= reg_wdata;
        3'd2: stage_q[31:0]  <= reg_wdata;
        3'd3: if (do_load) stage_q <= idx_ok ? tbl[tbl_idx] : '0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (do_commit) begin
      tbl[tbl_idx] <= stage_q;
    end else if (do_clear) begin
      for (int i = 0; i < DEPTH; i++) tbl[i][61:60] <= 2'd0;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {28'd0, stage_q[67:64]};
      3'd1:    reg_rdata = stage_q[63:32];
      3'd2:    reg_rdata = stage_q[31:0];
      default: reg_rdata = '0;
    endcase
  end

  assign ent_type = stage_q[61:60];
  assign ent_mac  = stage_q[47:0];

  a_r2_word0_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 3'd0 |-> reg_rdata[31:4] == 28'd0);

  a_r5_commit_keeps_stage: assert property (@(posedge clk) disable iff (!rst_n)
    do_commit |=> $stable(stage_q));

  a_r4_commit_stores: assert property (@(posedge clk) disable iff (!rst_n)
    do_commit |=> tbl[$past(tbl_idx)] == $past(stage_q));

  a_r6_far_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (do_load && !idx_ok) |=> stage_q == '0);

  a_r8_clear_frees: assert property (@(posedge clk) disable iff (!rst_n)
    do_clear |=> (tbl[0][61:60] == 2'd0 && tbl[DEPTH-1][61:60] == 2'd0 && $stable(stage_q)));

  a_r10_high_offsets_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr >= 3'd3 |-> reg_rdata == 32'd0);
endmodule

// File: tb/test_lut_window.sv
module test_lut_window;
  localparam int DEPTH = 64;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [1:0]  ent_type;
  logic [47:0] ent_mac;

  lut_window #(.DEPTH(DEPTH), .IDXF_W(16)) i_lut_window (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ent_type(ent_type), .ent_mac(ent_mac));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit run = 0, done = 0;
  logic [67:0] m_tbl [DEPTH];
  logic [67:0] m_data;

  task automatic chk(input string tag, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] a, input logic [31:0] d);
    int idx;
    idx = int'(d[15:0]);
    case (a)
      3'd0: m_data[67:64] = d[3:0];
      3'd1: m_data[63:32] = d;
      3'd2: m_data[31:0]  = d;
      3'd3: begin
        if (d[31]) begin
          if (idx < DEPTH) m_tbl[idx] = m_data;
        end else begin
          m_data = (idx < DEPTH) ? m_tbl[idx] : 68'd0;
        end
      end
      3'd4: if (d[0]) foreach (m_tbl[i]) m_tbl[i][61:60] = 2'd0;
      default: ;
    endcase
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    model(a, d);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rdw(input string tag, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, 68'(reg_rdata), 68'(exp));
  endtask

  task automatic rd_stage(input string tag);
    rdw(tag, 3'd0, {28'd0, m_data[67:64]});
    rdw(tag, 3'd1, m_data[63:32]);
    rdw(tag, 3'd2, m_data[31:0]);
  endtask

  task automatic put_stage(input logic [67:0] v);
    wr(3'd0, {28'd0, v[67:64]});
    wr(3'd1, v[63:32]);
    wr(3'd2, v[31:0]);
  endtask

  function automatic logic [67:0] pat(input int i);
    logic [31:0] hi, lo;
    hi = (32'(i) * 32'h0001_0203) ^ (32'h1000_0000 * 32'(i % 4)) ^ 32'h0A00_0000;
    lo = ~(32'(i) * 32'h0101_0101);
    return {4'(i + 5), hi, lo};
  endfunction

  always @(negedge clk) begin
    if (run) begin
      #1;
      chk("R9 ent_type", 68'(ent_type), 68'(m_data[61:60]));
      chk("R9 ent_mac", 68'(ent_mac), 68'(m_data[47:0]));
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (m_tbl[i]) m_tbl[i] = '0;
    m_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    run = 1;

    // R1: reset state
    rd_stage("R1 stage after reset");
    chk("R1 ent_type reset", 68'(ent_type), 68'd0);
    wr(3'd3, 32'd5);
    rd_stage("R1 entry after reset");

    // R2: word layout, upper bits of word 0 drop
    wr(3'd0, 32'hFFFF_FFFF);
    rdw("R2 word0 upper zero", 3'd0, 32'h0000_000F);
    // R9: MAC byte 0 at bits 47:40 (word1 15:8), type address=1 at word1 29:28
    wr(3'd1, 32'h1000_0211);
    wr(3'd2, 32'h2233_4455);
    chk("R9 mac order", 68'(ent_mac), 68'h0211_2233_4455);
    chk("R9 type address", 68'(ent_type), 68'd1);
    rdw("R2 word1", 3'd1, 32'h1000_0211);

    // R4/R5: commit then staging unchanged
    put_stage(pat(3));
    wr(3'd3, 32'h8000_0003);
    rd_stage("R5 stage after commit");
    chk("R5 stage value", 68'(ent_mac), 68'(pat(3)) & 68'hFFFF_FFFF_FFFF);
    wr(3'd3, 32'd7);
    rd_stage("R3 load empty entry");
    wr(3'd3, 32'd3);
    rd_stage("R3 load committed");
    chk("R4 entry 3 word1", 68'(m_data), pat(3));

    // R3/R4: fill whole table and read back
    for (int i = 0; i < DEPTH; i++) begin
      put_stage(pat(i));
      wr(3'd3, 32'h8000_0000 | 32'(i));
    end
    for (int i = DEPTH - 1; i >= 0; i -= 7) begin
      wr(3'd3, 32'(i));
      rd_stage($sformatf("R3 load %0d", i));
    end

    // R6: far loads
    wr(3'd3, 32'd10);
    wr(3'd3, 32'(DEPTH));
    rd_stage("R6 far load");
    chk("R6 zero", 68'(m_data), 68'd0);
    wr(3'd3, 32'd11);
    wr(3'd3, 32'h0000_FFFF);
    rd_stage("R6 far load max");

    // R7: far commit aliasing index 3 changes nothing
    put_stage(68'hF_FFFF_FFFF_FFFF_FFFF);
    wr(3'd3, 32'h8000_0000 | 32'(DEPTH + 3));
    wr(3'd3, 32'h8000_FFFF);
    wr(3'd3, 32'd3);
    rd_stage("R7 entry 3 intact");
    wr(3'd3, 32'd0);
    rd_stage("R7 entry 0 intact");

    // R10: high offsets
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd_stage("R10 stage untouched");
    rdw("R10 offset3", 3'd3, 32'd0);
    rdw("R10 offset4", 3'd4, 32'd0);
    rdw("R10 offset5", 3'd5, 32'd0);
    rdw("R10 offset7", 3'd7, 32'd0);

    // R8: clear, no-op with bit 0 low first
    wr(3'd3, 32'd2);
    wr(3'd4, 32'h0000_0002);
    wr(3'd3, 32'd2);
    rd_stage("R8 clear bit0 low");
    wr(3'd4, 32'd1);
    rd_stage("R8 stage kept on clear");
    for (int i = 0; i < DEPTH; i += 5) begin
      wr(3'd3, 32'(i));
      rd_stage($sformatf("R8 entry %0d", i));
      chk("R8 type free", 68'(ent_type), 68'd0);
    end

    // R4 after clear: rewrite, reload
    put_stage(pat(9));
    wr(3'd3, 32'h8000_0021);
    wr(3'd3, 32'd1);
    wr(3'd3, 32'h21);
    rd_stage("R4 recommit");

    run = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule